// File: doc/BRIEF.md
# Buffered Capture Channel with Edge Counter

This block serves one timer input channel. When a qualified edge arrives on the input, the channel stores the current value of a free-running timer in a capture register. An 8-bit counter advances on each such edge. Its limit is selectable: it either wraps around or stops at its maximum. The capture register and the counter each have a holding register. Software can read the holding registers while the live registers keep running.

The holding registers work in one of two buffering modes. In queue mode, every new capture first pushes the old capture value into the holding register. In latch mode, the live registers run freely. A latch event then copies the capture value and the count together into their holding registers and restarts the count from zero. A latch event comes from a modulus down-counter outside the block, which raises one strobe for it. Software can also raise a latch event with a one-cycle force strobe. The edge detector, the timer and the interrupt logic sit outside this block.

Top module: `cap_buf_chan`

## Requirements
- R1: On every cycle with `edge_pulse` high, `cap_q` loads `timer_val`, whatever the mode and buffer enable. With no edge, `cap_q` holds its value.
- R2: With `sat_en` low, each edge adds one to `cnt_q`, and an edge at 0xFF takes it to 0x00.
- R3: With `sat_en` high, `cnt_q` stops at 0xFF, so further edges leave it at 0xFF.
- R4: While `buf_en` is low, `cap_hold` and `cnt_hold` never change, in either mode, whatever the edge, latch or force inputs do.
- R5: Queue mode is selected by `buf_en` high and `latch_mode` low. In this mode an edge copies the old `cap_q` into `cap_hold` in the same cycle that `cap_q` takes the new timer value. `cnt_hold` is left untouched.
- R6: Latch mode is selected by `buf_en` high and `latch_mode` high. In this mode a `latch_evt` cycle copies `cap_q` to `cap_hold` and `cnt_q` to `cnt_hold`. Edges without a latch event update only `cap_q` and `cnt_q`.
- R7: A latch transfer clears `cnt_q`. When an edge falls in the same cycle, the holding registers get the values from before the edge, and `cnt_q` ends at 1.
- R8: A `force_latch` pulse acts exactly like `latch_evt` in latch mode. In queue mode, or with `buf_en` low, it is ignored.
- R9: After reset, `cap_q`, `cap_hold`, `cnt_q` and `cnt_hold` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Free-running timer value |
| edge_pulse | input | 1 | One-cycle pulse for each qualified input edge |
| buf_en | input | 1 | Enables transfers into the holding registers |
| latch_mode | input | 1 | 1 selects latch mode, 0 selects queue mode |
| sat_en | input | 1 | 1 makes the counter stop at 0xFF, 0 makes it wrap |
| latch_evt | input | 1 | Latch-event strobe from the modulus down-counter |
| force_latch | input | 1 | Software force-latch strobe, one cycle |
| cap_q | output | 16 | Capture register |
| cap_hold | output | 16 | Capture holding register |
| cnt_q | output | 8 | Edge counter |
| cnt_hold | output | 8 | Edge counter holding register |

## Verification
The bench first applies edges with the buffer disabled, using a timer value that changes every cycle. This separates the capture path from the holding path. Long edge trains then run past 255 with the limit off and then on, which distinguishes wrapping from saturation. In queue mode, edges at several spacings show whether the holding register gets the previous capture or the new one. In latch mode, edges are mixed with latch events, forced latches and coincident edge-plus-latch cycles. These patterns expose wrong clear ordering, force strobes that leak into queue mode, and holding registers that follow the live values between latches.

// File: rtl/cap_buf_chan.sv
module cap_buf_chan #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          edge_pulse,
  input  logic          buf_en,
  input  logic          latch_mode,
  input  logic          sat_en,
  input  logic          latch_evt,
  input  logic          force_latch,
  output logic [TW-1:0] cap_q,
  output logic [TW-1:0] cap_hold,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_hold
);

  logic          latch_go;
  logic          q_push;
  logic [CW-1:0] cnt_base;
  logic [CW-1:0] cnt_next;

  assign latch_go = buf_en & latch_mode & (latch_evt | force_latch);
  assign q_push   = buf_en & ~latch_mode & edge_pulse;
  assign cnt_base = latch_go ? '0 : cnt_q;
  assign cnt_next = !edge_pulse ? cnt_base :
                    (sat_en && (&cnt_base)) ? cnt_base : cnt_base + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      cap_hold <= '0;
      cnt_q    <= '0;
      cnt_hold <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (edge_pulse) cap_q <= timer_val;
      if (q_push || latch_go) cap_hold <= cap_q;
      if (latch_go) cnt_hold <= cnt_q;
    end
  end

endmodule

module cap_buf_chan_chk #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] timer_val,
  input logic          edge_pulse,
  input logic          buf_en,
  input logic          latch_mode,
  input logic          sat_en,
  input logic          latch_evt,
  input logic          force_latch,
  input logic [TW-1:0] cap_q,
  input logic [TW-1:0] cap_hold,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cnt_hold
);
  logic go;
  assign go = buf_en && latch_mode && (latch_evt || force_latch);

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> cap_q == $past(timer_val));
  a_r1_hold_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_pulse |=> $stable(cap_q));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && !sat_en && !go && (&cnt_q)) |=> cnt_q == '0);
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && sat_en && !go && (&cnt_q)) |=> (&cnt_q));
  a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> ($stable(cap_hold) && $stable(cnt_hold)));
  a_r5_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !latch_mode && edge_pulse) |=>
      (cap_hold == $past(cap_q) && $stable(cnt_hold)));
  a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cap_hold == $past(cap_q) && cnt_hold == $past(cnt_q)));
  a_r6_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && latch_mode && !latch_evt && !force_latch) |=>
      ($stable(cap_hold) && $stable(cnt_hold)));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !edge_pulse) |=> cnt_q == '0);
  a_r7_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (go && edge_pulse) |=> cnt_q == CW'(1));
  a_r8_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (force_latch && !latch_evt && !edge_pulse && !(buf_en && latch_mode)) |=>
      ($stable(cap_hold) && $stable(cnt_hold) && $stable(cnt_q)));
endmodule

bind cap_buf_chan cap_buf_chan_chk #(.TW(TW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .edge_pulse(edge_pulse),
  .buf_en(buf_en), .latch_mode(latch_mode), .sat_en(sat_en),
  .latch_evt(latch_evt), .force_latch(force_latch), .cap_q(cap_q),
  .cap_hold(cap_hold), .cnt_q(cnt_q), .cnt_hold(cnt_hold)
);

// File: tb/cap_buf_chan_tb.sv
module cap_buf_chan_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_val = '0;
  logic        edge_pulse = 1'b0, buf_en = 1'b0, latch_mode = 1'b0, sat_en = 1'b0;
  logic        latch_evt = 1'b0, force_latch = 1'b0;
  logic [15:0] cap_q, cap_hold;
  logic [7:0]  cnt_q, cnt_hold;

  typedef struct {
    logic [15:0] cap;
    logic [15:0] caph;
    logic [7:0]  cnt;
    logic [7:0]  cnth;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  logic [15:0] m_cap = '0, m_caph = '0;
  logic [7:0]  m_cnt = '0, m_cnth = '0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_buf_chan dut_i (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .edge_pulse(edge_pulse),
    .buf_en(buf_en), .latch_mode(latch_mode), .sat_en(sat_en),
    .latch_evt(latch_evt), .force_latch(force_latch), .cap_q(cap_q),
    .cap_hold(cap_hold), .cnt_q(cnt_q), .cnt_hold(cnt_hold)
  );

  task automatic check(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected registers.
  task automatic drive(string req, bit e, bit be, bit lm, bit se, bit le, bit fl);
    bit go;
    logic [7:0] base;
    @(negedge clk);
    timer_val  = timer_val + 16'h0101;
    edge_pulse = e; buf_en = be; latch_mode = lm; sat_en = se;
    latch_evt  = le; force_latch = fl;
    go   = be && lm && (le || fl);
    base = go ? 8'h00 : m_cnt;
    if (go) begin m_caph = m_cap; m_cnth = m_cnt; end
    else if (be && !lm && e) m_caph = m_cap;
    if (e) begin
      m_cap = timer_val;
      if (!(se && base == 8'hFF)) base = base + 8'h01;
    end
    m_cnt = base;
    sb.push_back('{m_cap, m_caph, m_cnt, m_cnth, req});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive("R1", 0, buf_en, latch_mode, sat_en, 0, 0);
  endtask

  // Monitor: compares each queued expectation just after the clock edge.
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        x = sb.pop_front();
        check(x.req, "cap_q", cap_q, x.cap);
        check(x.req, "cap_hold", cap_hold, x.caph);
        check(x.req, "cnt_q", cnt_q, x.cnt);
        check(x.req, "cnt_hold", cnt_hold, x.cnth);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", "cap_q", cap_q, 0);
    check("R9", "cap_hold", cap_hold, 0);
    check("R9", "cnt_q", cnt_q, 0);
    check("R9", "cnt_hold", cnt_hold, 0);
    @(negedge clk) rst_n = 1'b1;

    // R1/R4: capture with buffering off, latch and force attempts ignored
    for (int i = 0; i < 6; i++) drive("R1", i % 2, 0, 0, 0, 0, 0);
    drive("R4", 1, 0, 1, 0, 1, 0);
    drive("R4", 0, 0, 1, 0, 0, 1);
    drive("R4", 1, 0, 0, 0, 1, 1);
    idle(2);

    // R2: wrap past 0xFF
    for (int i = 0; i < 260; i++) drive("R2", 1, 0, 0, 0, 0, 0);
    // R3: saturate
    for (int i = 0; i < 270; i++) drive("R3", 1, 0, 0, 1, 0, 0);
    idle(1);

    // R5: queue mode, varied spacing; latch strobes do nothing
    for (int i = 0; i < 12; i++) drive("R5", (i % 3) != 1, 1, 0, 0, i == 5, 0);
    // R8: force ignored in queue mode
    drive("R8", 0, 1, 0, 0, 0, 1);
    drive("R8", 0, 1, 0, 0, 0, 1);

    // R6: latch mode, edges only then event
    for (int i = 0; i < 7; i++) drive("R6", 1, 1, 1, 0, 0, 0);
    drive("R6", 0, 1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) drive("R6", i % 2, 1, 1, 0, 0, 0);
    // R7: latch together with edge
    drive("R7", 1, 1, 1, 0, 1, 0);
    drive("R7", 1, 1, 1, 0, 0, 0);
    drive("R7", 1, 1, 1, 1, 1, 0);
    // R8: force latch in latch mode, with and without edge
    for (int i = 0; i < 3; i++) drive("R8", 1, 1, 1, 0, 0, 0);
    drive("R8", 0, 1, 1, 0, 0, 1);
    drive("R8", 1, 1, 1, 0, 0, 0);
    drive("R8", 1, 1, 1, 0, 0, 1);
    // R3: saturated count latched and cleared
    for (int i = 0; i < 300; i++) drive("R3", 1, 1, 1, 1, 0, 0);
    drive("R7", 0, 1, 1, 1, 1, 0);
    // R4: disabled in latch mode after activity
    for (int i = 0; i < 4; i++) drive("R4", 1, 0, 1, 0, 1, i % 2);
    idle(3);

    while (sb.size() > 0) @(posedge clk);
    #2;
    done = 1;
    finish_run();
  end
endmodule